// File: doc/BRIEF.md
# Soft-Ramping Stereo Digital Volume

This block scales a stereo stream of signed audio samples by a digital gain chosen per channel with an 8-bit attenuation code. A code selects a gain on a logarithmic scale with 0.375 dB resolution. Sixteen codes make one 6 dB octave, and the table runs from +24 dB at code 0 down to -71.25 dB at code 254. Code 255 silences the channel.

A newly written code is not applied at once. Each channel keeps a running code that moves one step toward its target on every sample frame, so a large change of volume becomes a sequence of small gain steps with no audible click. A link input makes the right channel follow the left channel's target code. The running code is turned into a linear multiplier: a 16-entry mantissa table covers the position inside the octave, and a barrel shift covers whole octaves. The product is saturated to the sample width and registered.

Top module: `soft_volume`

## Requirements
- R1: After reset, out_valid is 0, both outputs are 0, and both running codes are 255, so the first frame after reset produces zero on both channels.
- R2: For a running code c in 0..254, the output equals in * 2^(4 - c/16) within 2 LSB plus a relative error of 6e-5, rounded toward minus infinity.
- R3: On each cycle with frame_valid high, a channel's running code moves exactly one step toward its target (up if below, down if above, unchanged if equal). When frame_valid is low it does not change.
- R4: A frame presented with frame_valid high is scaled with the running code held before that frame's step. The result appears on the outputs in the next cycle, with out_valid high for exactly that one cycle.
- R5: Results beyond the 24-bit signed range saturate to 8388607 or -8388608.
- R6: A running code of 255 forces the channel's output to 0 for any input.
- R7: With link high, the right channel's target is vol_l, and vol_r has no effect on the right output.
- R8: With link low, each channel ramps toward its own code and its output depends only on its own input and code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One stereo sample frame is present on in_l/in_r |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| vol_l | input | 8 | Left target code (0 = +24 dB, 255 = mute) |
| vol_r | input | 8 | Right target code |
| link | input | 1 | Right channel follows vol_l |
| out_valid | output | 1 | Scaled frame present on out_l/out_r |
| out_l | output | 24 | Left scaled sample, signed, saturated |
| out_r | output | 24 | Right scaled sample, signed, saturated |

## Verification
The bench builds the block with its default 24-bit samples and 8-bit codes, so every code from 255 down to 0 can be reached in a few hundred frames, and the +24 dB end is crossed by a whole ramp. With a gain of sixteen at code 0, moderate inputs reach both saturation limits. Frames are sent with and without idle cycles between them, so the ramp is also shown to hold still while no frame arrives.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int STEP_BITS = 4;                 // 16 codes per 6 dB octave
  localparam int MANT_W    = 16;                // unsigned mantissa, Q1.15
  localparam int MANT_FRAC = 15;
  localparam int HEAD_OCT  = 4;                 // +24 dB headroom = 4 octaves
  localparam int N_CH      = 2;
endpackage

// File: rtl/vol_ramp_ch.sv
module vol_ramp_ch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [CODE_W-1:0] tgt_i,
  output logic [CODE_W-1:0] cur_o
);
  localparam logic [CODE_W-1:0] MUTE_CODE = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] ONE       = CODE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o <= MUTE_CODE;
    end else if (step_i) begin
      if (cur_o < tgt_i)      cur_o <= cur_o + ONE;
      else if (cur_o > tgt_i) cur_o <= cur_o - ONE;
    end
  end

  AST_RAMP_UP: assert property (@(posedge clk) disable iff (rst)
    step_i && (tgt_i > cur_o) |=> cur_o == $past(cur_o) + ONE); // R3
  AST_RAMP_DOWN: assert property (@(posedge clk) disable iff (rst)
    step_i && (tgt_i < cur_o) |=> cur_o == $past(cur_o) - ONE); // R3
  AST_RAMP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cur_o)); // R3
endmodule

// File: rtl/vol_gain_lut.sv
module vol_gain_lut
  import vol_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0]           code_i,
  output logic [MANT_W-1:0]           mant_o,
  output logic [CODE_W-STEP_BITS-1:0] oct_o,
  output logic                        mute_o
);
  logic [STEP_BITS-1:0] frac;

  assign frac   = code_i[STEP_BITS-1:0];
  assign oct_o  = code_i[CODE_W-1:STEP_BITS];
  assign mute_o = &code_i;

  // 2^(-f/16) in Q1.15
  always_comb begin
    unique case (frac)
      4'd0:  mant_o = 16'd32768;
      4'd1:  mant_o = 16'd31379;
      4'd2:  mant_o = 16'd30048;
      4'd3:  mant_o = 16'd28774;
      4'd4:  mant_o = 16'd27554;
      4'd5:  mant_o = 16'd26386;
      4'd6:  mant_o = 16'd25268;
      4'd7:  mant_o = 16'd24196;
      4'd8:  mant_o = 16'd23170;
      4'd9:  mant_o = 16'd22188;
      4'd10: mant_o = 16'd21247;
      4'd11: mant_o = 16'd20347;
      4'd12: mant_o = 16'd19484;
      4'd13: mant_o = 16'd18658;
      4'd14: mant_o = 16'd17867;
      default: mant_o = 16'd17110;
    endcase
  end
endmodule

// File: rtl/vol_scale.sv
module vol_scale
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int OCT_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [MANT_W-1:0]          mant_i,
  input  logic [OCT_W-1:0]           oct_i,
  input  logic                       mute_i,
  output logic signed [SAMPLE_W-1:0] result_o
);
  localparam int WIDE_W = SAMPLE_W + MANT_W + HEAD_OCT + 2;
  localparam logic signed [WIDE_W-1:0] SAT_MAX = WIDE_W'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] SAT_MIN = -(WIDE_W'(2 ** (SAMPLE_W - 1)));

  logic signed [WIDE_W-1:0] s_ext, m_ext, prod, shifted;
  logic signed [SAMPLE_W-1:0] clipped;
  int unsigned shamt;

  always_comb begin
    s_ext   = WIDE_W'(sample_i);
    m_ext   = WIDE_W'($signed({1'b0, mant_i}));
    prod    = (s_ext * m_ext) <<< HEAD_OCT;
    shamt   = MANT_FRAC + int'(oct_i);
    shifted = prod >>> shamt;
    if (shifted > SAT_MAX)      clipped = SAMPLE_W'(SAT_MAX);
    else if (shifted < SAT_MIN) clipped = SAMPLE_W'(SAT_MIN);
    else                        clipped = SAMPLE_W'(shifted);
  end

  always_ff @(posedge clk) begin
    if (rst)       result_o <= '0;
    else if (en_i) result_o <= mute_i ? '0 : clipped;
  end

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    en_i && mute_i |=> result_o == '0); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(result_o)); // R4
endmodule

// File: rtl/soft_volume.sv
module soft_volume
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_valid,
  input  logic signed [SAMPLE_W-1:0] in_l,
  input  logic signed [SAMPLE_W-1:0] in_r,
  input  logic [CODE_W-1:0]          vol_l,
  input  logic [CODE_W-1:0]          vol_r,
  input  logic                       link,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_l,
  output logic signed [SAMPLE_W-1:0] out_r
);
  localparam int OCT_W = CODE_W - STEP_BITS;

  logic signed [SAMPLE_W-1:0] smp [N_CH];
  logic signed [SAMPLE_W-1:0] res [N_CH];
  logic [CODE_W-1:0]          tgt [N_CH];
  logic [CODE_W-1:0]          cur [N_CH];

  assign smp[0] = in_l;
  assign smp[1] = in_r;
  assign tgt[0] = vol_l;
  assign tgt[1] = link ? vol_l : vol_r;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [MANT_W-1:0] mant;
    logic [OCT_W-1:0]  oct;
    logic              mute;

    vol_ramp_ch #(.CODE_W(CODE_W)) u_ramp (
      .clk(clk), .rst(rst), .step_i(frame_valid),
      .tgt_i(tgt[ch]), .cur_o(cur[ch])
    );

    vol_gain_lut #(.CODE_W(CODE_W)) u_lut (
      .code_i(cur[ch]), .mant_o(mant), .oct_o(oct), .mute_o(mute)
    );

    vol_scale #(.SAMPLE_W(SAMPLE_W), .OCT_W(OCT_W)) u_scale (
      .clk(clk), .rst(rst), .en_i(frame_valid), .sample_i(smp[ch]),
      .mant_i(mant), .oct_i(oct), .mute_i(mute), .result_o(res[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= frame_valid;
  end

  assign out_l = res[0];
  assign out_r = res[1];

  AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    link && frame_valid && (cur[0] == cur[1]) |=> cur[0] == cur[1]); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> !out_valid); // R4
endmodule

// File: tb/soft_volume_tb.sv
module soft_volume_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int WATCHDOG = 100000;
  localparam int SMAX = 8388607;
  localparam int SMIN = -8388608;

  typedef struct {
    int    exp_l;
    int    exp_r;
    int    code_l;
    int    code_r;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_valid = 1'b0;
  logic signed [SW-1:0] in_l = '0, in_r = '0;
  logic [7:0] vol_l = 8'd255, vol_r = 8'd255;
  logic link = 1'b0;
  logic out_valid;
  logic signed [SW-1:0] out_l, out_r;

  int checks = 0;
  int errors = 0;
  int m_l = 255, m_r = 255;   // model of running codes
  item_t q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_volume u_dut (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .in_l(in_l), .in_r(in_r),
    .vol_l(vol_l), .vol_r(vol_r), .link(link),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  function automatic int exp_val(int x, int c);
    real e;
    if (c == 255) return 0;
    e = x * (2.0 ** (4.0 - c / 16.0));
    if (e >= SMAX) return SMAX;
    if (e <= SMIN) return SMIN;
    return int'($floor(e));
  endfunction

  function automatic bit close(int act, int ex, int c);
    real tol;
    if (c == 255 || ex == SMAX || ex == SMIN) return act == ex;
    tol = 2.0 + ((ex < 0) ? -ex : ex) * 6.0e-5;
    return ((act - ex) <= tol) && ((ex - act) <= tol);
  endfunction

  function automatic int step(int cur, int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  task automatic send(int l, int r, int gap, string tag);
    item_t it;
    int tr;
    tr = link ? int'(vol_l) : int'(vol_r);
    it.code_l = m_l;
    it.code_r = m_r;
    it.exp_l  = exp_val(l, m_l);
    it.exp_r  = exp_val(r, m_r);
    it.tag    = tag;
    q.push_back(it);
    m_l = step(m_l, int'(vol_l));
    m_r = step(m_r, tr);
    in_l = SW'(l);
    in_r = SW'(r);
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R4 out_valid during idle act=%0b exp=0", out_valid);
      end
    end
  endtask

  // monitor: compare every produced frame against the queue
  always @(negedge clk) begin
    if (!rst && out_valid === 1'b1) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected out_valid act=1 exp=0");
      end else begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (!close(int'(out_l), it.exp_l, it.code_l)) begin
          errors++;
          $display("FAIL %s left code=%0d act=%0d exp=%0d", it.tag, it.code_l, out_l, it.exp_l);
        end
        checks++;
        if (!close(int'(out_r), it.exp_r, it.code_r)) begin
          errors++;
          $display("FAIL %s right code=%0d act=%0d exp=%0d", it.tag, it.code_r, out_r, it.exp_r);
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d cycles exp=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_l !== '0 || out_r !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs act=%0b/%0d/%0d exp=0/0/0", out_valid, out_l, out_r);
    end

    // R1 / R6: first frame after reset is muted
    vol_l = 8'd0; vol_r = 8'd0;
    send(500000, -500000, 0, "R1");
    // R3 / R2: full ramp from 254 to 0, alternating gaps
    for (int k = 0; k < 256; k++)
      send(1000 + 37 * k, -2000 + 11 * k, k % 3, "R2");

    // R5: saturation at +24 dB
    send(1 << 20, -(1 << 20), 0, "R5");
    send(8388607, -8388608, 1, "R5");
    send(300000, -300000, 0, "R2");

    // R8: independent targets
    vol_l = 8'd100; vol_r = 8'd40;
    for (int k = 0; k < 110; k++)
      send(4000000 - 30000 * k, -3000000 + 25000 * k, k % 2, "R8");

    // R3: long idle, then confirm codes unchanged
    repeat (20) @(negedge clk);
    send(2000000, 2000000, 0, "R3");

    // R7: link, vol_r ignored
    link = 1'b1; vol_l = 8'd60; vol_r = 8'd200;
    for (int k = 0; k < 70; k++)
      send(1500000, -1234567 + k, 0, "R7");
    vol_r = 8'd3;
    for (int k = 0; k < 5; k++)
      send(-777777, 654321, 1, "R7");

    // R6: ramp to mute code
    link = 1'b0; vol_l = 8'd255; vol_r = 8'd255;
    for (int k = 0; k < 200; k++)
      send(8000000 - k, -8000000 + k, 0, "R6");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R4 pending results act=%0d exp=0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule